// File: doc/BRIEF.md
# IDE Interrupt Status and Gate

This block is the interrupt register bank of a multi-port IDE host adapter. It samples the raw interrupt request level of up to three IDE ports, lets the host read each level back as bit 7 of a byte-wide status location, and decides whether those requests reach the single shared level-2 interrupt line of the host bus. The whole bank sits in a 256-byte page of the adapter's local address space. That page is split into four 64-byte slots, and every address inside a slot aliases the same location.

After reset the host interrupt line stays blocked, so a drive that raises its request line during power-up cannot stall the boot. Software opens the gate by writing any value anywhere in the last slot. From then on only a reset can close the gate, and there is no way to read the gate back. A static configuration input selects a two-port build. In that build the third port is treated as absent: its status reads as idle and its request never reaches the host.

The request inputs are asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops before it is used. Status reads return data one clock after the read strobe, and that data is held until the next read.

Top module: `ide_irq_status_gate`

## Requirements
- R1: A read at page offset 0x00–0x3F (slot index `addr_i[7:6]` = 0) returns the synchronized port 0 request level in bit 7.
- R2: A read at page offset 0x40–0x7F (slot index 1) returns the synchronized port 1 request level in bit 7.
- R3: A read at page offset 0x80–0xBF (slot index 2) in three-port mode (`two_port_i` = 0) returns the synchronized port 2 request level in bit 7.
- R4: Bits 6:0 of `rdata_o` are always 0. A read at offset 0xC0–0xFF (slot index 3), or a read outside the page (`addr_i[ADDR_W-1:8]` != `WIN_PAGE`), returns 0x00. The read result appears on `rdata_o` one clock after `rd_en_i` and holds until the next read.
- R5: A write anywhere in slot 3 of the page sets the gate flag, whatever the value on `wdata_i`.
- R6: Writes to slots 0–2, and writes outside the page, leave the gate flag unchanged.
- R7: Reset clears the gate flag, `host_irq_o` and `rdata_o`. Once set, the gate flag is cleared by nothing except reset.
- R8: `host_irq_o` is a register. After each clock it equals the gate flag ANDed with the OR of the synchronized, unmasked port requests, both taken as they stood before that clock.
- R9: In two-port mode (`two_port_i` = 1), a slot 2 read returns 0x00 and port 2's request has no effect on `host_irq_o`.
- R10: A change on `ide_irq_i` becomes visible to status reads and to the gate after `SYNC_STAGES` clocks of synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Local byte address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data (value ignored) |
| rdata_o | output | 8 | Registered read data |
| two_port_i | input | 1 | 1 = two-port build; port 2 treated as absent |
| ide_irq_i | input | 3 | Raw asynchronous IDE request levels, bit n = port n |
| host_irq_o | output | 1 | Shared level-2 interrupt to the host |

## Verification
Status reads go to several addresses in each slot, including the first and last byte, with each port's request raised alone and with all ports raised. This distinguishes a wrong slot decode or a missing alias from a correct one. Writes carrying varied data go first to slots 0–2 and to addresses outside the page, and only then to slot 3. This separates a gate that opens on the right slot from one that opens on any write. A mid-run reset checks that the gate closes again. Requests on port 2 are repeated with the two-port input set and cleared, and a request is raised just before a read to expose the synchronizer delay.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_PORTS  = 3;
  localparam int STATUS_BIT = 7;
  localparam int SLOT_W     = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_PORT0 = 2'd0,
    SLOT_PORT1 = 2'd1,
    SLOT_PORT2 = 2'd2,
    SLOT_GATE  = 2'd3
  } slot_e;
endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ide_irq_decode.sv
module ide_irq_decode
  import ide_irq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-9:0] WIN_PAGE = 'h0F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output slot_e             slot_o
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [5:0]        unused_alias;

  assign page         = addr_i[ADDR_W-1:8];
  assign unused_alias = addr_i[5:0];  // alias bits inside a slot
  assign hit_o        = (page == WIN_PAGE);
  assign slot_o       = slot_e'(addr_i[7:6]);
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate #(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [NUM_PORTS-1:0] irq_i,
  output logic                 en_o,
  output logic                 host_irq_o
);
  logic en_q, host_q;

  // sticky: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_q <= 1'b0;
    else         host_q <= en_q & (|irq_i);
  end

  assign en_o       = en_q;
  assign host_irq_o = host_q;
endmodule

// File: rtl/ide_irq_status_gate.sv
module ide_irq_status_gate
  import ide_irq_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-9:0] WIN_PAGE    = 'h0F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 two_port_i,
  input  logic [NUM_PORTS-1:0] ide_irq_i,
  output logic                 host_irq_o
);
  logic [NUM_PORTS-1:0] irq_sync, irq_live;
  logic                 hit, gate_en, gate_set;
  slot_e                slot;
  logic [7:0]           rd_next, rdata_q;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;  // write value is don't-care

  ide_irq_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ide_irq_i),
    .q_o   (irq_sync)
  );

  ide_irq_decode #(.ADDR_W(ADDR_W), .WIN_PAGE(WIN_PAGE)) dec_i (
    .addr_i(addr_i),
    .hit_o (hit),
    .slot_o(slot)
  );

  // port 2 treated as absent in two-port build
  assign irq_live = {irq_sync[2] & ~two_port_i, irq_sync[1:0]};
  assign gate_set = wr_en_i & hit & (slot == SLOT_GATE);

  ide_irq_gate #(.NUM_PORTS(NUM_PORTS)) gate_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (gate_set),
    .irq_i     (irq_live),
    .en_o      (gate_en),
    .host_irq_o(host_irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (hit) begin
      unique case (slot)
        SLOT_PORT0: rd_next[STATUS_BIT] = irq_live[0];
        SLOT_PORT1: rd_next[STATUS_BIT] = irq_live[1];
        SLOT_PORT2: rd_next[STATUS_BIT] = irq_live[2];
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ide_irq_status_gate_chk.sv
module ide_irq_status_gate_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-9:0] WIN_PAGE = 'h0F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic              two_port_i,
  input logic [7:0]        rdata_o,
  input logic              host_irq_o,
  input logic              gate_en_i
);
  logic in_page, gate_wr, p2_rd, gate_rd;

  assign in_page = (addr_i[ADDR_W-1:8] == WIN_PAGE);
  assign gate_wr = wr_en_i && in_page && (addr_i[7:6] == 2'd3);
  assign p2_rd   = rd_en_i && in_page && (addr_i[7:6] == 2'd2);
  assign gate_rd = rd_en_i && in_page && (addr_i[7:6] == 2'd3);

  assert_low_bits_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6:0] == 7'd0);

  assert_gate_slot_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_rd |=> rdata_o == 8'd0);

  assert_write_opens_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_wr |=> gate_en_i);

  assert_gate_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_i |=> gate_en_i);

  assert_closed_gate_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> !host_irq_o);

  assert_two_port_p2_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_rd && two_port_i) |=> rdata_o == 8'd0);
endmodule

bind ide_irq_status_gate ide_irq_status_gate_chk #(
  .ADDR_W(ADDR_W), .WIN_PAGE(WIN_PAGE)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .two_port_i(two_port_i),
  .rdata_o   (rdata_o),
  .host_irq_o(host_irq_o),
  .gate_en_i (gate_en)
);

// File: tb/ide_irq_status_gate_tb_top.sv
module ide_irq_status_gate_tb_top;
  localparam int ADDR_W = 16;
  localparam int SYNC   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rd_en = 1'b0, wr_en = 1'b0, two_port = 1'b0;
  logic [7:0]        wdata = '0;
  logic [2:0]        irq = '0;
  logic [7:0]        rdata;
  logic              host_irq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ide_irq_status_gate #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .two_port_i(two_port), .ide_irq_i(irq),
    .host_irq_o(host_irq)
  );

  // behavioural reference
  logic [2:0] hist[$];
  bit         m_en, m_host;
  logic [7:0] m_rdata;

  function automatic logic [7:0] status_of(logic [ADDR_W-1:0] a, logic [2:0] s, bit tp);
    int slot;
    if (a[ADDR_W-1:8] != 8'h0F) return 8'h00;
    slot = int'(a[7:6]);
    if (slot == 3) return 8'h00;
    if (slot == 2 && tp) return 8'h00;
    return s[slot] ? 8'h80 : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < SYNC; i++) hist.push_back(3'b000);
      m_en = 0; m_host = 0; m_rdata = 8'h00;
    end else begin
      logic [2:0] s;
      s = hist[SYNC-1];
      if (two_port) s[2] = 1'b0;
      if (rd_en) m_rdata = status_of(addr, hist[SYNC-1], two_port);
      m_host = m_en && (s != 3'b000);
      if (wr_en && addr[ADDR_W-1:8] == 8'h0F && addr[7:6] == 2'd3) m_en = 1;
      hist.push_front(irq);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R8 host_irq per-cycle", {7'd0, host_irq}, {7'd0, m_host});
    chk("R4 rdata per-cycle", rdata, m_rdata);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    chk("R7 reset rdata", rdata, 8'h00);
    chk("R7 reset host_irq", {7'd0, host_irq}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R1 and R2 through every slot alias edge
    irq = 3'b001; idle(SYNC + 1);
    rd(16'h0F00, d); chk("R1 port0 first alias", d, 8'h80);
    rd(16'h0F3F, d); chk("R1 port0 last alias", d, 8'h80);
    rd(16'h0F40, d); chk("R2 port1 idle", d, 8'h00);
    irq = 3'b010; idle(SYNC + 1);
    rd(16'h0F7F, d); chk("R2 port1 last alias", d, 8'h80);
    rd(16'h0F15, d); chk("R1 port0 idle", d, 8'h00);
    chk("R8 gate closed blocks irq", {7'd0, host_irq}, 8'h00);

    // R3 three-port mode
    irq = 3'b100; idle(SYNC + 1);
    rd(16'h0F80, d); chk("R3 port2 first alias", d, 8'h80);
    rd(16'h0FBF, d); chk("R3 port2 last alias", d, 8'h80);

    // R4 gate slot and outside page
    irq = 3'b111; idle(SYNC + 1);
    rd(16'h0FC0, d); chk("R4 gate slot reads zero", d, 8'h00);
    rd(16'h1F00, d); chk("R4 outside page zero", d, 8'h00);
    rd(16'h0E40, d); chk("R4 other page zero", d, 8'h00);
    idle(2); chk("R4 rdata holds", rdata, 8'h00);

    // R6 stray writes
    wr(16'h0F00, 8'hFF); wr(16'h0FBF, 8'h55); wr(16'h1FC0, 8'hAA);
    idle(3); chk("R6 stray writes keep gate closed", {7'd0, host_irq}, 8'h00);

    // R5 zero data still opens gate
    wr(16'h0FE7, 8'h00);
    idle(2); chk("R5 any write opens gate", {7'd0, host_irq}, 8'h01);

    // R9 two-port masking
    two_port = 1'b1; irq = 3'b100; idle(SYNC + 2);
    rd(16'h0F80, d); chk("R9 port2 reads idle", d, 8'h00);
    chk("R9 port2 no host irq", {7'd0, host_irq}, 8'h00);
    irq = 3'b001; idle(SYNC + 2);
    chk("R9 port0 still reaches host", {7'd0, host_irq}, 8'h01);
    two_port = 1'b0; irq = 3'b100; idle(SYNC + 2);
    chk("R3 port2 reaches host in three-port", {7'd0, host_irq}, 8'h01);

    // R10 synchronizer delay
    irq = 3'b000; idle(SYNC + 2);
    @(negedge clk); irq = 3'b010; addr = 16'h0F40; rd_en = 1'b1;
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      chk("R10 not yet visible", rdata, 8'h00);
    end
    @(negedge clk); rd_en = 1'b0;
    chk("R10 visible after delay", rdata, 8'h80);

    // R7 gate closes only on reset
    idle(4); chk("R7 gate held open", {7'd0, host_irq}, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(SYNC + 3);
    chk("R7 reset closes gate", {7'd0, host_irq}, 8'h00);
    rd(16'h0F40, d); chk("R2 status live after reset", d, 8'h80);
    wr(16'h0FC0, 8'h3C); idle(2);
    chk("R5 reopen after reset", {7'd0, host_irq}, 8'h01);
    irq = 3'b000; idle(SYNC + 2);
    chk("R8 host drops with requests", {7'd0, host_irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule